// File: doc/BRIEF.md
# VME Slave Transfer Controller

This block is the slave side of a VMEbus board interface. It watches the bus address strobe, and when a master starts a cycle it captures the address and address modifier into registers. It then shows them on a decode port, where logic outside the block decides whether the board is addressed. After a fixed decode window the controller samples the decoder's hit input. If the board is selected, it turns the bus cycle into a level request toward a synchronous user-side register or memory port.

The byte lanes for the user side come from the two data strobes, address bit 1 and the long-word signal. Strobe combinations outside the supported set are not served. A user ready ends the request. For a read, the user data is latched onto the bus data output, and DTACK is pulled low until the master lets go of the address strobe. A bus error during the request drops it, and no acknowledge is given. The block also drives the active-low enables and the direction line of the data transceivers.

All bus strobes and the bus error line pass through two-flop synchronizers into the local board clock. Address, modifier, write and long-word lines are taken as stable once the strobe has been seen low.

Top module: `vme_slave_ctrl`

## Requirements
- R1: One clock after the synchronized address strobe is seen falling while idle, `dec_addr`/`usr_addr` and `dec_am`/`usr_am` carry the `bus_addr` and `bus_am` values present at that edge, and they hold until the next strobe fall.
- R2: `dec_hit` is sampled only at the clock edge DEC_CYC = ceil(DEC_WIN_NS / CLK_PERIOD_NS) cycles after the capture edge (5 with defaults). If it is low there, the cycle gets no request and no DTACK, even if it was high earlier.
- R3: `usr_be` bit n enables data bits 8n+7:8n. With long-word high, DS0 alone gives 4'b0001, DS1 alone gives 4'b0010, and both strobes give 4'b0011, whatever address bit 1 is (`bus_addr[0]`). With long-word low, address bit 1 low and both strobes, the result is 4'b1111. `usr_be` is valid while `usr_req` is high and zero otherwise.
- R4: `usr_req` is raised one clock after the data strobes are seen stable and supported. It then stays high until a clock edge at which `usr_rdy` is high or the synchronized bus error is low.
- R5: At the clock edge where `usr_rdy` ends the request, `bus_dtack_n` goes low. For a read, `bus_rdata` takes the `usr_rdata` value from that edge. For a write, `bus_rdata` stays zero.
- R6: `bus_dtack_n` stays low while the synchronized address strobe stays low. A new cycle starts only on a fresh strobe fall after the release.
- R7: For a write (`bus_write_n` low), `usr_rd_wr_n` is low and `usr_wdata` carries `bus_wdata` during the request. For a read, `usr_rd_wr_n` is high and `usr_wdata` is zero.
- R8: Both transceiver enables are low from the request until the release. `xcvr_to_bus` is high only during a selected read, and the enables are high whenever the block is idle.
- R9: One clock after the synchronized address strobe is seen high in the acknowledge phase, `bus_dtack_n` and both enables return high, `xcvr_to_bus` and `bus_rdata` return to zero, and the controller is idle again.
- R10: A strobe combination not listed in R3 (for example both strobes with long-word low and address bit 1 high) produces no request and no DTACK.
- R11: A synchronized bus error during the request drops `usr_req` and the enables on the next clock, and DTACK is never given for that cycle.
- R12: After reset, `bus_dtack_n`, `usr_rd_wr_n` and both enables are high, and `usr_req`, `usr_be`, `xcvr_to_bus` and `bus_rdata` are zero.
- R13: If the address strobe is seen high again before the decode sample, the cycle is abandoned with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local board clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 31 | Bus address bits 31:1 (index 0 is address bit 1) |
| bus_am | input | 6 | Bus address modifier |
| bus_wdata | input | 32 | Write data from the bus |
| bus_rdata | output | 32 | Read data toward the bus |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_ds0_n | input | 1 | Data strobe for bits 7:0, active low |
| bus_ds1_n | input | 1 | Data strobe for bits 15:8, active low |
| bus_lword_n | input | 1 | Long-word transfer, active low |
| bus_write_n | input | 1 | Low for a write |
| bus_berr_n | input | 1 | Bus error, active low |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| xcvr_ext_oe_n | output | 1 | External transceiver enable, active low |
| xcvr_int_oe_n | output | 1 | Internal transceiver enable, active low |
| xcvr_to_bus | output | 1 | Transceiver direction, high toward the bus |
| dec_addr | output | 31 | Captured address for the external decoder |
| dec_am | output | 6 | Captured modifier for the external decoder |
| dec_hit | input | 1 | Board selected, from the external decoder |
| usr_req | output | 1 | User access request, level |
| usr_rdy | input | 1 | User access ready |
| usr_addr | output | 31 | Address for the user side |
| usr_am | output | 6 | Modifier for the user side |
| usr_wdata | output | 32 | Write data for the user side |
| usr_rdata | input | 32 | Read data from the user side, valid with ready |
| usr_rd_wr_n | output | 1 | High for read, low for write |
| usr_be | output | 4 | Byte enables, bit n covers bits 8n+7:8n |

## Verification
The assertions check the timing rules on every cycle. A request is only raised after the full decode window. The request is held until ready or bus error, and DTACK falls only after a ready. DTACK stays low until the strobe is released and is then dropped within one clock. A bus error kills the request without an acknowledge. The transceivers point toward the bus only while they are enabled. The byte-lane mapping, the rejection of unsupported strobe sets, the late-hit and aborted cycles, and the read and write data paths can only be shown by the bench's scenarios. There, a behavioural model predicts every output on every clock.

// File: rtl/vmes_pkg.sv
package vmes_pkg;
    localparam int ADDR_W = 31;
    localparam int AM_W   = 6;
    localparam int DATA_W = 32;
    localparam int NLANE  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_STROBE,
        ST_REQ,
        ST_ACK,
        ST_DRAIN
    } st_e;
endpackage

// File: rtl/vmes_sync.sv
module vmes_sync #(
    parameter int             W    = 4,
    parameter logic [W-1:0]   INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Two-stage synchronizer, one chain per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sh_q;
        logic [1:0] sh_d;
        always_comb sh_d = {sh_q[0], d[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {2{INIT[i]}};
            else        sh_q <= sh_d;
        end
        assign q[i] = sh_q[1];
    end
endmodule

// File: rtl/vmes_capture.sv
module vmes_capture
    import vmes_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [AM_W-1:0]   am_in,
    input  logic              wr_n_in,
    input  logic              lw_n_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic [AM_W-1:0]   am_o,
    output logic              wr_n_o,
    output logic              lw_n_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [AM_W-1:0]   am;
        logic              wr_n;
        logic              lw_n;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.addr = addr_in;
            c_d.am   = am_in;
            c_d.wr_n = wr_n_in;
            c_d.lw_n = lw_n_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.addr <= '0;
            c_q.am   <= '0;
            c_q.wr_n <= 1'b1;
            c_q.lw_n <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign addr_o = c_q.addr;
    assign am_o   = c_q.am;
    assign wr_n_o = c_q.wr_n;
    assign lw_n_o = c_q.lw_n;
endmodule

// File: rtl/vmes_lanes.sv
module vmes_lanes
    import vmes_pkg::*;
(
    input  logic             ds0_n,
    input  logic             ds1_n,
    input  logic             lw_n,
    input  logic             a1,
    output logic [NLANE-1:0] be,
    output logic             ok
);
    // Supported strobe sets; everything else is refused.
    always_comb begin
        be = '0;
        ok = 1'b0;
        unique case ({lw_n, ds1_n, ds0_n})
            3'b110: begin be = NLANE'(4'b0001); ok = 1'b1; end
            3'b101: begin be = NLANE'(4'b0010); ok = 1'b1; end
            3'b100: begin be = NLANE'(4'b0011); ok = 1'b1; end
            3'b000: begin
                if (!a1) begin
                    be = '1;
                    ok = 1'b1;
                end
            end
            default: begin
                be = '0;
                ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vme_slave_ctrl.sv
module vme_slave_ctrl
    import vmes_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int DEC_WIN_NS    = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [AM_W-1:0]   bus_am,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_as_n,
    input  logic              bus_ds0_n,
    input  logic              bus_ds1_n,
    input  logic              bus_lword_n,
    input  logic              bus_write_n,
    input  logic              bus_berr_n,
    output logic              bus_dtack_n,
    output logic              xcvr_ext_oe_n,
    output logic              xcvr_int_oe_n,
    output logic              xcvr_to_bus,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [AM_W-1:0]   dec_am,
    input  logic              dec_hit,
    output logic              usr_req,
    input  logic              usr_rdy,
    output logic [ADDR_W-1:0] usr_addr,
    output logic [AM_W-1:0]   usr_am,
    output logic [DATA_W-1:0] usr_wdata,
    input  logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rd_wr_n,
    output logic [NLANE-1:0]  usr_be
);
    localparam int DEC_RAW = (DEC_WIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int DEC_CYC = (DEC_RAW < 1) ? 1 : DEC_RAW;
    localparam int CNT_W   = $clog2(DEC_CYC + 1);

    typedef struct packed {
        st_e               state;
        logic [CNT_W-1:0]  cnt;
        logic              as_prev;
        logic [1:0]        ds_prev;
        logic              req;
        logic              dtack_n;
        logic              oe_n;
        logic              to_bus;
        logic              rd_wr_n;
        logic [NLANE-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t r_d, r_q;

    // Synchronized strobes: [0] AS, [1] DS0, [2] DS1, [3] BERR (all active low)
    logic [3:0] sync_q;
    logic       as_s;
    logic [1:0] ds_s;
    logic       berr_sn;

    vmes_sync #(.W(4), .INIT(4'hF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_berr_n, bus_ds1_n, bus_ds0_n, bus_as_n}),
        .q     (sync_q)
    );

    assign as_s    = sync_q[0];
    assign ds_s    = sync_q[2:1];
    assign berr_sn = sync_q[3];

    logic              cap_load;
    logic [ADDR_W-1:0] cap_addr;
    logic [AM_W-1:0]   cap_am;
    logic              cap_wr_n;
    logic              cap_lw_n;

    vmes_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cap_load),
        .addr_in (bus_addr),
        .am_in   (bus_am),
        .wr_n_in (bus_write_n),
        .lw_n_in (bus_lword_n),
        .addr_o  (cap_addr),
        .am_o    (cap_am),
        .wr_n_o  (cap_wr_n),
        .lw_n_o  (cap_lw_n)
    );

    logic [NLANE-1:0] lane_be;
    logic             lane_ok;

    vmes_lanes u_lanes (
        .ds0_n (ds_s[0]),
        .ds1_n (ds_s[1]),
        .lw_n  (cap_lw_n),
        .a1    (cap_addr[0]),
        .be    (lane_be),
        .ok    (lane_ok)
    );

    always_comb begin
        r_d         = r_q;
        cap_load    = 1'b0;
        r_d.as_prev = as_s;
        r_d.ds_prev = ds_s;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.as_prev && !as_s) begin
                    cap_load  = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (as_s) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt == CNT_W'(DEC_CYC - 1)) begin
                    r_d.state = dec_hit ? ST_STROBE : ST_DRAIN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_STROBE: begin
                if (as_s) begin
                    r_d.state = ST_IDLE;
                end else if (ds_s != 2'b11 && ds_s == r_q.ds_prev) begin
                    if (lane_ok) begin
                        r_d.state   = ST_REQ;
                        r_d.req     = 1'b1;
                        r_d.be      = lane_be;
                        r_d.rd_wr_n = cap_wr_n;
                        r_d.wdata   = cap_wr_n ? '0 : bus_wdata;
                        r_d.oe_n    = 1'b0;
                        r_d.to_bus  = cap_wr_n;
                    end else begin
                        r_d.state = ST_DRAIN;
                    end
                end
            end
            ST_REQ: begin
                if (!berr_sn) begin
                    r_d.state   = ST_DRAIN;
                    r_d.req     = 1'b0;
                    r_d.be      = '0;
                    r_d.wdata   = '0;
                    r_d.rd_wr_n = 1'b1;
                    r_d.oe_n    = 1'b1;
                    r_d.to_bus  = 1'b0;
                end else if (usr_rdy) begin
                    r_d.state   = ST_ACK;
                    r_d.req     = 1'b0;
                    r_d.be      = '0;
                    r_d.wdata   = '0;
                    r_d.rd_wr_n = 1'b1;
                    r_d.dtack_n = 1'b0;
                    r_d.rdata   = cap_wr_n ? usr_rdata : '0;
                end
            end
            ST_ACK: begin
                if (as_s) begin
                    r_d.state   = ST_IDLE;
                    r_d.dtack_n = 1'b1;
                    r_d.oe_n    = 1'b1;
                    r_d.to_bus  = 1'b0;
                    r_d.rdata   = '0;
                end
            end
            ST_DRAIN: begin
                if (as_s) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.as_prev <= 1'b1;
            r_q.ds_prev <= 2'b11;
            r_q.req     <= 1'b0;
            r_q.dtack_n <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.to_bus  <= 1'b0;
            r_q.rd_wr_n <= 1'b1;
            r_q.be      <= '0;
            r_q.wdata   <= '0;
            r_q.rdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata     = r_q.rdata;
    assign bus_dtack_n   = r_q.dtack_n;
    assign xcvr_ext_oe_n = r_q.oe_n;
    assign xcvr_int_oe_n = r_q.oe_n;
    assign xcvr_to_bus   = r_q.to_bus;
    assign dec_addr      = cap_addr;
    assign dec_am        = cap_am;
    assign usr_addr      = cap_addr;
    assign usr_am        = cap_am;
    assign usr_req       = r_q.req;
    assign usr_wdata     = r_q.wdata;
    assign usr_rd_wr_n   = r_q.rd_wr_n;
    assign usr_be        = r_q.be;

    // Assertion support: cycles elapsed since the last capture, saturating.
    logic [CNT_W:0] since_cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_cap_q <= '1;
        else if (cap_load)         since_cap_q <= '0;
        else if (since_cap_q != '1) since_cap_q <= since_cap_q + 1'b1;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && r_q.as_prev && !as_s)
        |=> (dec_addr == $past(bus_addr) && dec_am == $past(bus_am)));

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_req) |-> (since_cap_q >= (CNT_W+1)'(DEC_CYC + 1)));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(usr_req) && !$past(usr_rdy) && $past(berr_sn)) |-> usr_req);

    p_dtack_after_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_dtack_n) |-> ($past(usr_req) && $past(usr_rdy)));

    p_dtack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bus_dtack_n) && !$past(as_s)) |-> !bus_dtack_n);

    p_drive_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_to_bus |-> (!xcvr_ext_oe_n && !xcvr_int_oe_n && usr_rd_wr_n));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!bus_dtack_n) && $past(as_s))
        |-> (bus_dtack_n && xcvr_ext_oe_n && !xcvr_to_bus));

    p_berr_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(usr_req) && !$past(berr_sn)) |-> (!usr_req && bus_dtack_n));
endmodule

// File: tb/vme_slave_ctrl_tb.sv
module vme_slave_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_as_n = 1'b1, bus_ds0_n = 1'b1, bus_ds1_n = 1'b1;
    logic        bus_lword_n = 1'b1, bus_write_n = 1'b1, bus_berr_n = 1'b1;
    logic        bus_dtack_n, xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_to_bus;
    logic [30:0] dec_addr;
    logic [5:0]  dec_am;
    logic        dec_hit = 1'b0;
    logic        usr_req;
    logic        usr_rdy = 1'b0;
    logic [30:0] usr_addr;
    logic [5:0]  usr_am;
    logic [31:0] usr_wdata;
    logic [31:0] usr_rdata = '0;
    logic        usr_rd_wr_n;
    logic [3:0]  usr_be;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    vme_slave_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_am(bus_am), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_as_n(bus_as_n), .bus_ds0_n(bus_ds0_n), .bus_ds1_n(bus_ds1_n),
        .bus_lword_n(bus_lword_n), .bus_write_n(bus_write_n), .bus_berr_n(bus_berr_n),
        .bus_dtack_n(bus_dtack_n), .xcvr_ext_oe_n(xcvr_ext_oe_n), .xcvr_int_oe_n(xcvr_int_oe_n),
        .xcvr_to_bus(xcvr_to_bus), .dec_addr(dec_addr), .dec_am(dec_am), .dec_hit(dec_hit),
        .usr_req(usr_req), .usr_rdy(usr_rdy), .usr_addr(usr_addr), .usr_am(usr_am),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_rd_wr_n(usr_rd_wr_n), .usr_be(usr_be)
    );

    // ---------------- behavioural reference ----------------
    localparam int WIN = 5; // 50 ns at 10 ns
    logic [3:0]  seen_q[$];
    int          phase, waited;
    logic        last_as;
    logic [1:0]  last_ds;
    logic        m_req, m_dtack_n, m_oe_n, m_dir, m_rw_n, m_wr_lat, m_lw_lat;
    logic [3:0]  m_be;
    logic [31:0] m_wd, m_rd;
    logic [30:0] m_addr;
    logic [5:0]  m_am;

    function automatic logic [4:0] lanes(input logic lw, input logic a1, input logic [1:0] ds);
        // returns {ok, be}
        if (lw && ds == 2'b10) return 5'b1_0001;
        if (lw && ds == 2'b01) return 5'b1_0010;
        if (lw && ds == 2'b00) return 5'b1_0011;
        if (!lw && !a1 && ds == 2'b00) return 5'b1_1111;
        return 5'b0_0000;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q = '{4'hF, 4'hF};
            phase = 0; waited = 0; last_as = 1'b1; last_ds = 2'b11;
            m_req = 0; m_dtack_n = 1; m_oe_n = 1; m_dir = 0; m_rw_n = 1;
            m_be = 0; m_wd = 0; m_rd = 0; m_addr = 0; m_am = 0; m_wr_lat = 1; m_lw_lat = 1;
        end else begin
            logic [3:0] s;
            logic       a_s, e_s;
            logic [1:0] d_s;
            logic [4:0] ln;
            s = seen_q.pop_front();
            seen_q.push_back({bus_berr_n, bus_ds1_n, bus_ds0_n, bus_as_n});
            a_s = s[0]; d_s = s[2:1]; e_s = s[3];
            case (phase)
                0: if (last_as && !a_s) begin
                       m_addr = bus_addr; m_am = bus_am;
                       m_wr_lat = bus_write_n; m_lw_lat = bus_lword_n;
                       waited = 0; phase = 1;
                   end
                1: if (a_s) phase = 0;
                   else if (waited == WIN - 1) phase = dec_hit ? 2 : 5;
                   else waited++;
                2: if (a_s) phase = 0;
                   else if (d_s != 2'b11 && d_s == last_ds) begin
                       ln = lanes(m_lw_lat, m_addr[0], d_s);
                       if (ln[4]) begin
                           m_req = 1; m_be = ln[3:0]; m_rw_n = m_wr_lat;
                           m_wd = m_wr_lat ? 32'h0 : bus_wdata;
                           m_oe_n = 0; m_dir = m_wr_lat; phase = 3;
                       end else phase = 5;
                   end
                3: if (!e_s) begin
                       m_req = 0; m_be = 0; m_wd = 0; m_rw_n = 1; m_oe_n = 1; m_dir = 0; phase = 5;
                   end else if (usr_rdy) begin
                       m_req = 0; m_be = 0; m_wd = 0; m_rw_n = 1; m_dtack_n = 0;
                       m_rd = m_wr_lat ? usr_rdata : 32'h0; phase = 4;
                   end
                4: if (a_s) begin
                       m_dtack_n = 1; m_oe_n = 1; m_dir = 0; m_rd = 0; phase = 0;
                   end
                default: if (a_s) phase = 0;
            endcase
            last_as = a_s;
            last_ds = d_s;
        end
    end

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R1 dec_addr", 64'(dec_addr), 64'(m_addr));
            cmp("R1 dec_am", 64'(dec_am), 64'(m_am));
            cmp("R1 usr_addr", 64'(usr_addr), 64'(m_addr));
            cmp("R4 usr_req", 64'(usr_req), 64'(m_req));
            cmp("R3 usr_be", 64'(usr_be), 64'(m_be));
            cmp("R7 usr_rd_wr_n", 64'(usr_rd_wr_n), 64'(m_rw_n));
            cmp("R7 usr_wdata", 64'(usr_wdata), 64'(m_wd));
            cmp("R5/R6/R9 bus_dtack_n", 64'(bus_dtack_n), 64'(m_dtack_n));
            cmp("R5 bus_rdata", 64'(bus_rdata), 64'(m_rd));
            cmp("R8 xcvr_ext_oe_n", 64'(xcvr_ext_oe_n), 64'(m_oe_n));
            cmp("R8 xcvr_int_oe_n", 64'(xcvr_int_oe_n), 64'(m_oe_n));
            cmp("R8 xcvr_to_bus", 64'(xcvr_to_bus), 64'(m_dir));
        end
    end

    // hit_mode: 0 never, 1 steady, 2 only early in the window
    task automatic run_cycle(input logic [30:0] a, input logic [5:0] am, input logic wr_n,
                             input logic lw_n, input logic d0, input logic d1,
                             input logic [31:0] wd, input logic [31:0] rd, input int hit_mode,
                             input int rdy_dly, input bit berr, input int abort_after);
        int n;
        @(negedge clk);
        bus_addr = a; bus_am = am; bus_write_n = wr_n; bus_lword_n = lw_n; bus_wdata = wd;
        bus_as_n = 1'b0; bus_ds0_n = d0; bus_ds1_n = d1;
        dec_hit = (hit_mode != 0);
        if (abort_after > 0) begin
            repeat (abort_after) @(negedge clk);
        end else begin
            n = 0;
            while (!usr_req && n < 20) begin
                @(negedge clk);
                n++;
                if (hit_mode == 2 && n == 3) dec_hit = 1'b0;
            end
            if (usr_req) begin
                repeat (rdy_dly) @(negedge clk);
                if (berr) begin
                    bus_berr_n = 1'b0;
                    @(negedge clk);
                end else begin
                    usr_rdy = 1'b1; usr_rdata = rd;
                    @(negedge clk);
                    usr_rdy = 1'b0; usr_rdata = 32'hDEAD_0000;
                end
            end
            repeat (5) @(negedge clk);
        end
        bus_as_n = 1'b1; bus_ds0_n = 1'b1; bus_ds1_n = 1'b1; dec_hit = 1'b0;
        repeat (6) @(negedge clk);
        bus_berr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state at the ports
        cmp("R12 dtack", 64'(bus_dtack_n), 64'd1);
        cmp("R12 req", 64'(usr_req), 64'd0);
        cmp("R12 be", 64'(usr_be), 64'd0);
        cmp("R12 rw", 64'(usr_rd_wr_n), 64'd1);
        cmp("R12 oe", 64'({xcvr_ext_oe_n, xcvr_int_oe_n, xcvr_to_bus}), 64'b110);
        cmp("R12 rdata", 64'(bus_rdata), 64'd0);

        // R3/R5/R8: 32-bit read, ready after two cycles
        run_cycle(31'h1234_5670, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'hCAFE_F00D, 1, 2, 0, 0);
        // R3/R7: byte write on DS0 only
        run_cycle(31'h0000_0101, 6'h3D, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_00A5, 32'h0, 1, 0, 0, 0);
        // R3/R7: byte write on DS1 only
        run_cycle(31'h0000_0202, 6'h39, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_5A00, 32'h0, 1, 1, 0, 0);
        // R3: 16-bit read with address bit 1 high
        run_cycle(31'h0000_0303, 6'h29, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_BEEF, 1, 0, 0, 0);
        // R4/R7: 32-bit write with a long ready delay
        run_cycle(31'h7FFF_FFFE, 6'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8765_4321, 32'h0, 1, 6, 0, 0);
        // R10: long word with address bit 1 high is refused
        run_cycle(31'h0000_0405, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h1111_1111, 1, 0, 0, 0);
        // R10: single strobe with long word is refused
        run_cycle(31'h0000_0504, 6'h09, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2222_2222, 32'h0, 1, 0, 0, 0);
        // R2: decoder never answers
        run_cycle(31'h0000_0600, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h3333_3333, 0, 0, 0, 0);
        // R2: hit only before the sample point
        run_cycle(31'h0000_0700, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h4444_4444, 2, 0, 0, 0);
        // R11: bus error while the request is pending
        run_cycle(31'h0000_0800, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h5555_5555, 1, 1, 1, 0);
        // R13: strobe released before the decode sample
        run_cycle(31'h0000_0900, 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h6666_6666, 1, 0, 0, 2);
        // R6/R9: back-to-back reads after a clean release
        run_cycle(31'h0000_0A00, 6'h0A, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0000_0077, 1, 0, 0, 0);
        run_cycle(31'h0000_0B00, 6'h0B, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0102_0304, 1, 3, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            miscmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end
endmodule